// File: doc/BRIEF.md
# FSK Tone Synthesizer with Bit Timing

This block produces the digital transmit waveform of a frequency-shift-keyed line modem. A 24-bit phase accumulator runs at the 16 MHz reference clock. On every cycle it advances by an increment that is read from a table built at elaboration. The table is keyed by one of eight carriers, one of four baud rates, a deviation choice and the bit being sent.

The two tones sit symmetrically around the carrier, half the tone spacing above it and half below it. A logic 0 uses the upper tone. The spacing is tied to the baud rate: it equals the baud rate, or half of it. At 600 baud a request for the half spacing is promoted to the full spacing, because the spacing must never fall below 600 Hz. A change of tone only changes the increment and never touches the accumulator, so the phase stays continuous across bit boundaries. The accumulator phase drives either a parabolic sine approximation or a square wave.

In asynchronous access the host times the bits itself: the data input picks the tone for the very next phase step, and the bit-clock output stays low. In synchronous access a bit-timing state machine generates a bit clock from a cycle divider, and the data input is captured on each rising edge of that clock. The machine has three states:
- `ST_FREE`: asynchronous, bit clock low.
- `ST_CLK_HIGH`: first half of a bit, bit clock high.
- `ST_CLK_LOW`: second half of a bit, bit clock low.

Its transitions are:
- FREE→CLK_HIGH: synchronous mode is requested. The data bit is captured.
- CLK_HIGH→CLK_LOW: the high count is complete.
- CLK_LOW→CLK_HIGH: the bit period is complete. The data bit is captured.
- CLK_HIGH→FREE or CLK_LOW→FREE: asynchronous mode is requested.

Top module: `fsk_tone_synth`

## Requirements
- R1: While `rst_n` is low, `phase_out` is 0 and `bit_clk` is 0. With `wave_sel`=0, `wave_out` is also 0.
- R2: On every clock edge `phase_out` advances by round(f·2^24/16e6) modulo 2^24, with f in Hz. f = carrier + spacing/2 when the selected bit is 0, and f = carrier − spacing/2 when it is 1. The `carrier_sel` codes 0..7 select 60000, 66000, 72000, 76000, 82050, 86000, 110000 and 132500 Hz.
- R3: The `baud_sel` codes 0..3 select 600, 1200, 2400 and 4800 baud. With `dev_sel`=1 the spacing equals the baud rate. With `dev_sel`=0 it equals half the baud rate.
- R4: At `baud_sel`=0 (600 baud), `dev_sel`=0 gives the same tones as `dev_sel`=1.
- R5: A change of tone never resets the accumulator. The phase after the edge equals the phase before it plus the new increment.
- R6: With `sync_mode`=0, the `tx_bit` value present at an edge selects the tone for that edge's phase step. `bit_clk` is 0 from the cycle after `sync_mode` is seen low.
- R7: With `sync_mode`=1 and a fixed baud rate, `bit_clk` has a period of P = round(16e6/baud) cycles and stays high for floor(P/2) of them. Its rising edge marks the start of a bit.
- R8: With `sync_mode`=1, `tx_bit` is captured only at the edge where `bit_clk` rises. That value sets the tone from the following phase step until the next capture. A change of `tx_bit` between captures has no effect on the tone.
- R9: With `wave_sel`=0, let p = `phase_out`[22:12] and m = min((p·(2048−p))>>9, 2047). `wave_out` is m when `phase_out`[23]=0 and −m when it is 1.
- R10: With `wave_sel`=1, `wave_out` is +2047 when `phase_out`[23]=0 and −2047 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_sel | input | 3 | Carrier code 0..7 |
| baud_sel | input | 2 | Baud code 0..3 |
| dev_sel | input | 1 | 1 = spacing equals the baud rate, 0 = spacing is half the baud rate |
| sync_mode | input | 1 | 1 = internal bit timing, 0 = host-timed bits |
| tx_bit | input | 1 | Serial data bit |
| wave_sel | input | 1 | 0 = sine sample, 1 = square sample |
| bit_clk | output | 1 | Bit-clock strobe for the host |
| phase_out | output | 24 | Oscillator phase |
| wave_out | output | 12 | Signed waveform sample |

## Verification
The checks on bit-clock period and high time assume that `baud_sel` and `sync_mode` stay constant across a whole bit. For that reason the checker drops its period window whenever either one changes. The tone-hold check assumes that carrier, baud and deviation codes are stable for two cycles in synchronous mode. The stimulus therefore changes configuration only in asynchronous mode, or well before the rising edge it measures, and it then waits for a second rising edge before it counts cycles.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    localparam int N_CARRIER = 8;
    localparam int N_BAUD    = 4;

    typedef enum logic [1:0] {
        ST_FREE,
        ST_CLK_HIGH,
        ST_CLK_LOW
    } timer_state_t;

    function automatic longint carrier_hz(input int idx);
        case (idx)
            0:       return 64'd60000;
            1:       return 64'd66000;
            2:       return 64'd72000;
            3:       return 64'd76000;
            4:       return 64'd82050;
            5:       return 64'd86000;
            6:       return 64'd110000;
            default: return 64'd132500;
        endcase
    endfunction

    function automatic longint baud_hz(input int idx);
        return 64'd600 << idx;
    endfunction

    // Spacing is halved only when the result stays at or above 600 Hz.
    function automatic longint spacing_hz(input int b, input int d);
        if (d == 0 && b != 0)
            return baud_hz(b) / 2;
        return baud_hz(b);
    endfunction

    function automatic longint tone_hz(input int c, input int b, input int d, input int bit_v);
        longint half;
        half = spacing_hz(b, d) / 2;
        if (bit_v != 0)
            return carrier_hz(c) - half;
        return carrier_hz(c) + half;
    endfunction

    function automatic longint phase_step(input longint f, input longint clk_hz, input int pw);
        return ((f << pw) + clk_hz / 2) / clk_hz;
    endfunction

    function automatic longint bit_period(input longint clk_hz, input int b);
        return (clk_hz + baud_hz(b) / 2) / baud_hz(b);
    endfunction

endpackage

// File: rtl/fsk_inc_table.sv
module fsk_inc_table
    import fsk_pkg::*;
#(
    parameter longint CLK_HZ  = 16_000_000,
    parameter int     PHASE_W = 24
) (
    input  logic [2:0]         carrier_sel,
    input  logic [1:0]         baud_sel,
    input  logic               dev_sel,
    input  logic               tone_bit,
    output logic [PHASE_W-1:0] inc
);
    localparam int N_ENTRY = N_CARRIER * N_BAUD * 4;

    logic [PHASE_W-1:0] tbl [N_ENTRY];

    for (genvar c = 0; c < N_CARRIER; c++) begin : g_car
        for (genvar b = 0; b < N_BAUD; b++) begin : g_baud
            for (genvar d = 0; d < 2; d++) begin : g_dev
                for (genvar t = 0; t < 2; t++) begin : g_bit
                    localparam longint STEP = phase_step(tone_hz(c, b, d, t), CLK_HZ, PHASE_W);
                    assign tbl[((c * N_BAUD + b) * 2 + d) * 2 + t] = PHASE_W'(STEP);
                end
            end
        end
    end

    assign inc = tbl[{carrier_sel, baud_sel, dev_sel, tone_bit}];

endmodule

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer
    import fsk_pkg::*;
#(
    parameter longint CLK_HZ = 16_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_mode,
    input  logic [1:0] baud_sel,
    input  logic       tx_bit,
    output logic       bit_clk,
    output logic       held_bit
);
    localparam int CNT_W = $clog2(bit_period(CLK_HZ, 0) + 1);

    logic [CNT_W-1:0] per_tbl [N_BAUD];
    logic [CNT_W-1:0] hi_tbl  [N_BAUD];

    for (genvar b = 0; b < N_BAUD; b++) begin : g_len
        localparam longint PER = bit_period(CLK_HZ, b);
        assign per_tbl[b] = CNT_W'(PER);
        assign hi_tbl[b]  = CNT_W'(PER / 2);
    end

    timer_state_t     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] hi_len, lo_len;
    logic             capture;

    assign hi_len = hi_tbl[baud_sel];
    assign lo_len = per_tbl[baud_sel] - hi_tbl[baud_sel];

    always_comb begin
        state_n = state;
        cnt_n   = cnt + 1'b1;
        unique case (state)
            ST_FREE: begin
                cnt_n = '0;
                if (sync_mode)
                    state_n = ST_CLK_HIGH;
            end
            ST_CLK_HIGH: begin
                if (!sync_mode) begin
                    state_n = ST_FREE;
                    cnt_n   = '0;
                end else if (cnt >= hi_len - 1'b1) begin
                    state_n = ST_CLK_LOW;
                    cnt_n   = '0;
                end
            end
            ST_CLK_LOW: begin
                if (!sync_mode) begin
                    state_n = ST_FREE;
                    cnt_n   = '0;
                end else if (cnt >= lo_len - 1'b1) begin
                    state_n = ST_CLK_HIGH;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_FREE;
                cnt_n   = '0;
            end
        endcase
    end

    assign capture = (state_n == ST_CLK_HIGH) && (state != ST_CLK_HIGH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_bit <= 1'b0;
        else if (capture)
            held_bit <= tx_bit;
    end

    assign bit_clk = (state == ST_CLK_HIGH);

endmodule

// File: rtl/fsk_wave_shaper.sv
module fsk_wave_shaper #(
    parameter int PHASE_W = 24,
    parameter int SAMP_W  = 12
) (
    input  logic [PHASE_W-1:0]       phase,
    input  logic                     wave_sel,
    output logic signed [SAMP_W-1:0] sample
);
    localparam int F = SAMP_W - 1;
    localparam logic [2*F:0] PEAK = (2*F+1)'((1 << F) - 1);

    logic [F-1:0] p;
    logic [F:0]   comp;
    logic [2*F:0] prod;
    logic [2*F:0] scaled;
    logic [F-1:0] mag;
    logic         neg;

    assign neg    = phase[PHASE_W-1];
    assign p      = phase[PHASE_W-2 -: F];
    assign comp   = (F+1)'(1 << F) - {1'b0, p};
    assign prod   = {{(F+1){1'b0}}, p} * {{F{1'b0}}, comp};
    assign scaled = prod >> (F - 2);
    assign mag    = (scaled > PEAK) ? PEAK[F-1:0] : scaled[F-1:0];

    always_comb begin
        if (wave_sel)
            sample = neg ? -$signed({1'b0, PEAK[F-1:0]}) : $signed({1'b0, PEAK[F-1:0]});
        else
            sample = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth #(
    parameter longint CLK_HZ  = 16_000_000,
    parameter int     PHASE_W = 24,
    parameter int     SAMP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               carrier_sel,
    input  logic [1:0]               baud_sel,
    input  logic                     dev_sel,
    input  logic                     sync_mode,
    input  logic                     tx_bit,
    input  logic                     wave_sel,
    output logic                     bit_clk,
    output logic [PHASE_W-1:0]       phase_out,
    output logic signed [SAMP_W-1:0] wave_out
);
    logic               held_bit;
    logic               tone_bit;
    logic [PHASE_W-1:0] inc;
    logic [PHASE_W-1:0] acc;

    fsk_bit_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .baud_sel  (baud_sel),
        .tx_bit    (tx_bit),
        .bit_clk   (bit_clk),
        .held_bit  (held_bit)
    );

    assign tone_bit = sync_mode ? held_bit : tx_bit;

    fsk_inc_table #(.CLK_HZ(CLK_HZ), .PHASE_W(PHASE_W)) u_table (
        .carrier_sel (carrier_sel),
        .baud_sel    (baud_sel),
        .dev_sel     (dev_sel),
        .tone_bit    (tone_bit),
        .inc         (inc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else
            acc <= acc + inc;
    end

    assign phase_out = acc;

    fsk_wave_shaper #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_shape (
        .phase    (acc),
        .wave_sel (wave_sel),
        .sample   (wave_out)
    );

endmodule

// File: rtl/fsk_tone_checks.sv
module fsk_tone_checks
    import fsk_pkg::*;
#(
    parameter longint CLK_HZ  = 16_000_000,
    parameter int     PHASE_W = 24,
    parameter int     SAMP_W  = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               carrier_sel,
    input logic [1:0]               baud_sel,
    input logic                     dev_sel,
    input logic                     sync_mode,
    input logic                     wave_sel,
    input logic                     bit_clk,
    input logic [PHASE_W-1:0]       phase_out,
    input logic signed [SAMP_W-1:0] wave_out
);
    localparam int CW = $clog2(bit_period(CLK_HZ, 0) + 1) + 1;
    localparam logic signed [SAMP_W-1:0] TOP = SAMP_W'((1 << (SAMP_W - 1)) - 1);

    logic [CW-1:0] per_exp [N_BAUD];
    for (genvar b = 0; b < N_BAUD; b++) begin : g_exp
        localparam longint PER = bit_period(CLK_HZ, b);
        assign per_exp[b] = CW'(PER);
    end

    logic               bc_q, rise, fall, rise_q, win_ok;
    logic [CW-1:0]      cyc;
    logic [1:0]         baud_q;
    logic [5:0]         cfg_q, cfg_qq;
    logic               sync_q, sync_qq;
    logic [PHASE_W-1:0] prev_phase, step, step_q;
    logic [1:0]         age;

    assign rise = bit_clk && !bc_q;
    assign fall = !bit_clk && bc_q;
    assign step = phase_out - prev_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q <= 1'b0; rise_q <= 1'b0; cyc <= '0; win_ok <= 1'b0; baud_q <= '0;
            cfg_q <= '0; cfg_qq <= '0; sync_q <= 1'b0; sync_qq <= 1'b0;
            prev_phase <= '0; step_q <= '0; age <= '0;
        end else begin
            bc_q    <= bit_clk;
            rise_q  <= rise;
            cyc     <= rise ? '0 : cyc + 1'b1;
            baud_q  <= baud_sel;
            if (!sync_mode || baud_sel != baud_q)
                win_ok <= 1'b0;
            else if (rise)
                win_ok <= 1'b1;
            cfg_q   <= {carrier_sel, baud_sel, dev_sel};
            cfg_qq  <= cfg_q;
            sync_q  <= sync_mode;
            sync_qq <= sync_q;
            prev_phase <= phase_out;
            step_q  <= step;
            if (age != 2'd3)
                age <= age + 1'b1;
        end
    end

    AST_ASYNC_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !bit_clk) else $error("async bit clock not low");  // R6

    AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && win_ok && sync_mode && baud_sel == baud_q) |-> (cyc == per_exp[baud_sel] - 1'b1))
        else $error("bit period wrong");  // R7

    AST_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && win_ok && sync_mode && baud_sel == baud_q) |-> (cyc == (per_exp[baud_sel] >> 1) - 1'b1))
        else $error("bit clock high time wrong");  // R7

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && sync_mode && sync_q && sync_qq && !rise_q &&
         cfg_q == {carrier_sel, baud_sel, dev_sel} && cfg_qq == cfg_q) |-> (step == step_q))
        else $error("tone changed between captures");  // R8

    AST_SINE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_sel |-> (phase_out[PHASE_W-1] ? (wave_out <= 0) : (wave_out >= 0)))
        else $error("sine sign wrong");  // R9

    AST_SQUARE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        wave_sel |-> (wave_out == (phase_out[PHASE_W-1] ? -TOP : TOP)))
        else $error("square level wrong");  // R10

endmodule

bind fsk_tone_synth fsk_tone_checks #(
    .CLK_HZ(CLK_HZ), .PHASE_W(PHASE_W), .SAMP_W(SAMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .carrier_sel(carrier_sel), .baud_sel(baud_sel),
    .dev_sel(dev_sel), .sync_mode(sync_mode), .wave_sel(wave_sel),
    .bit_clk(bit_clk), .phase_out(phase_out), .wave_out(wave_out)
);

// File: tb/sim_fsk_tone_synth.sv
module sim_fsk_tone_synth;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  carrier_sel = '0;
    logic [1:0]  baud_sel = '0;
    logic        dev_sel = 1'b1;
    logic        sync_mode = 1'b0;
    logic        tx_bit = 1'b0;
    logic        wave_sel = 1'b0;
    logic        bit_clk;
    logic [23:0] phase_out;
    logic signed [11:0] wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsk_tone_synth u0 (
        .clk(clk), .rst_n(rst_n), .carrier_sel(carrier_sel), .baud_sel(baud_sel),
        .dev_sel(dev_sel), .sync_mode(sync_mode), .tx_bit(tx_bit), .wave_sel(wave_sel),
        .bit_clk(bit_clk), .phase_out(phase_out), .wave_out(wave_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint car_f(input int c);
        longint t [8] = '{60000, 66000, 72000, 76000, 82050, 86000, 110000, 132500};
        return t[c];
    endfunction

    function automatic longint exp_inc(input int c, input int b, input int d, input int bv);
        longint baud, sp, f;
        baud = 600 * (1 << b);
        sp   = (d == 1 || b == 0) ? baud : baud / 2;
        f    = bv ? car_f(c) - sp / 2 : car_f(c) + sp / 2;
        return (f * 16777216 + 8000000) / 16000000;
    endfunction

    function automatic longint exp_wave(input logic [23:0] ph, input logic sq);
        longint p, m;
        if (sq) return ph[23] ? -2047 : 2047;
        p = ph[22:12];
        m = (p * (2048 - p)) >> 9;
        if (m > 2047) m = 2047;
        return ph[23] ? -m : m;
    endfunction

    function automatic longint dstep(input logic [23:0] a, input logic [23:0] b);
        logic [23:0] d;
        d = b - a;
        return d;
    endfunction

    task automatic wait_rise();
        logic prev;
        prev = bit_clk;
        forever begin
            @(negedge clk);
            if (bit_clk && !prev) break;
            prev = bit_clk;
        end
    endtask

    task automatic measure(input int b);
        int hi, per;
        longint p_exp;
        baud_sel = 2'(b);
        sync_mode = 1'b1;
        wait_rise();
        wait_rise();
        hi = 0; per = 0;
        while (bit_clk) begin hi++; per++; @(negedge clk); end
        while (!bit_clk) begin per++; @(negedge clk); end
        p_exp = (16000000 + (600 * (1 << b)) / 2) / (600 * (1 << b));
        chk("R7 period", per, p_exp);
        chk("R7 high", hi, p_exp / 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] p1, p2, last;
        repeat (3) @(negedge clk);
        chk("R1 phase", phase_out, 0);
        chk("R1 bit_clk", bit_clk, 0);
        chk("R1 wave", wave_out, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R9 R10: sweep every configuration in asynchronous mode
        for (int c = 0; c < 8; c++)
            for (int b = 0; b < 4; b++)
                for (int d = 0; d < 2; d++)
                    for (int t = 0; t < 2; t++) begin
                        carrier_sel = 3'(c); baud_sel = 2'(b); dev_sel = d[0]; tx_bit = t[0];
                        wave_sel = t[0] ^ d[0];
                        @(negedge clk); p1 = phase_out;
                        @(negedge clk); p2 = phase_out;
                        chk((b == 0 && d == 0) ? "R4 step" : (d == 0 ? "R3 step" : "R2 step"),
                            dstep(p1, p2), exp_inc(c, b, d, t));
                        chk(wave_sel ? "R10 square" : "R9 sine", wave_out, exp_wave(phase_out, wave_sel));
                    end

        // R4: 600 baud, both deviation codes give identical tones
        chk("R4 equal", exp_inc(3, 0, 0, 0), exp_inc(3, 0, 1, 0));

        // R5 and R6: tone change without phase reset
        carrier_sel = 3'd6; baud_sel = 2'd2; dev_sel = 1'b1; tx_bit = 1'b0;
        @(negedge clk); p1 = phase_out; tx_bit = 1'b1;
        @(negedge clk); chk("R5 continuity", phase_out, 24'(p1 + 24'(exp_inc(6, 2, 1, 1))));
        chk("R6 async bit_clk", bit_clk, 0);
        p1 = phase_out; tx_bit = 1'b0;
        @(negedge clk); chk("R6 direct tone", dstep(p1, phase_out), exp_inc(6, 2, 1, 0));

        // R7: bit clock timing
        carrier_sel = 3'd0; dev_sel = 1'b1; tx_bit = 1'b0;
        measure(3);
        measure(2);

        // R8: capture only at the rising edge of the bit clock
        baud_sel = 2'd3;
        wait_rise();
        repeat (100) @(negedge clk);
        tx_bit = 1'b1;
        repeat (10) @(negedge clk);
        p1 = phase_out; @(negedge clk);
        chk("R8 held old", dstep(p1, phase_out), exp_inc(0, 3, 1, 0));
        last = phase_out;
        begin
            logic prev;
            prev = bit_clk;
            forever begin
                @(negedge clk);
                if (bit_clk && !prev) break;
                prev = bit_clk;
                last = phase_out;
            end
        end
        chk("R8 rise step old", dstep(last, phase_out), exp_inc(0, 3, 1, 0));
        p1 = phase_out; @(negedge clk);
        chk("R8 new tone", dstep(p1, phase_out), exp_inc(0, 3, 1, 1));

        measure(0);

        sync_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 bit_clk low", bit_clk, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule